// File: doc/BRIEF.md
# Serial Memory Slave Front-End

This block is the device side of a small serial memory reached over a four-wire synchronous serial link: an active-low select, a clock driven only by the host, one data line in, and one data line out with its own output enable. It oversamples the link with the system clock and takes clock idle levels of either low (mode 0) or high (mode 3). It shifts bytes most significant bit first, treats the first byte after select as a command, and runs a small byte-wide register array in place of a nonvolatile store.

Reads stream bytes out from a 16-bit start address and the address keeps incrementing through the array. Writes first go into a one-page staging buffer, and the page is copied into the array only when select is released cleanly on a byte boundary. A pause input freezes a transfer in the middle without losing its place. An unknown command makes the slave go deaf and silent until select is asserted again.

Top module: `spi_mem_slave`

## Requirements
- R1: Input data is captured on rising clock edges and output data changes on falling clock edges, both with the clock idling low (mode 0) and idling high (mode 3).
- R2: Every byte is shifted most significant bit first in both directions.
- R3: Command byte 0x03 followed by a 16-bit address returns array bytes from that address onward, one per byte slot, with the address wrapping at the array end; address bits at and above log2(DEPTH) are ignored.
- R4: A first byte other than 0x06, 0x04, 0x05, 0x01, 0x03 or 0x02 makes the slave ignore all further input and keep its output disabled until the next assertion of select.
- R5: While select is high the output is disabled and clock and data activity changes no state.
- R6: A pause input driven low while the clock is low disables the output and freezes the bit position, so clock edges during the pause are ignored; driving it high again while the clock is low resumes the transfer where it stopped.
- R7: The status byte is {keep[5:0], armed, 0}. Command 0x06 sets armed and 0x04 clears it. Command 0x05 reads the status byte. Command 0x01 with one data byte stores data bits 7:2 into keep and clears armed, but only if armed was set; otherwise it changes nothing.
- R8: Command 0x02 plus a 16-bit address plus data bytes updates the array only if armed is set and select is released after a whole number of bytes. A committed write clears armed, and a write that is not committed leaves armed unchanged.
- R9: Write data lands at consecutive offsets within the 32-byte page holding the start address and wraps to the page start past its end; when a location is sent more than once, the last byte sent for it is kept.
- R10: After command 0x05 the status byte repeats for as many byte slots as the host clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data into the slave |
| spi_holdn | input | 1 | Active-low pause |
| spi_so | output | 1 | Serial data out of the slave |
| spi_so_oe | output | 1 | Output enable for spi_so (1 = drive) |

## Verification
The array is filled page by page with an arithmetic pattern, alternating between the two clock idle levels. It is then read back in one long stream whose address carries set upper bits, which separates a correct address truncation and increment from a stuck or misaligned address, and a second stream crosses the array end to show the wrap. Overlong page writes with a mid-page start tell last-byte-wins wrapping apart from spilling into the next page. Writes cut off mid-byte and writes sent while not armed must leave the array and status as they were. An unknown first byte followed by bytes that look like valid commands, clock activity while deselected, and pauses in the middle of a byte in both modes each check that input is ignored and the output stays off without the stream losing its place.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [3:0] {
    S_OP, S_AH, S_AL, S_RD, S_WR, S_SRR, S_SRW, S_SKIP, S_BAD
  } st_e;

  localparam logic [7:0] OP_ARM_SET = 8'h06;
  localparam logic [7:0] OP_ARM_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_MEM_RD  = 8'h03;
  localparam logic [7:0] OP_MEM_WR  = 8'h02;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic csn_i,
  input  logic si_i,
  input  logic holdn_i,
  output logic cs_act,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s,
  output logic hold
);
  logic [1:0] sck_m, csn_m, si_m, holdn_m;
  logic       sck_d, cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_m   <= 2'b00;
      csn_m   <= 2'b11;
      si_m    <= 2'b00;
      holdn_m <= 2'b11;
      sck_d   <= 1'b0;
      cs_d    <= 1'b0;
    end else begin
      sck_m   <= {sck_m[0], sck_i};
      csn_m   <= {csn_m[0], csn_i};
      si_m    <= {si_m[0], si_i};
      holdn_m <= {holdn_m[0], holdn_i};
      sck_d   <= sck_m[1];
      cs_d    <= cs_act;
    end
  end

  assign cs_act = ~csn_m[1];
  assign si_s   = si_m[1];

  // pause state changes only while the clock is low
  always_ff @(posedge clk) begin
    if (rst || !cs_act) hold <= 1'b0;
    else if (!sck_m[1]) hold <= ~holdn_m[1];
  end

  assign cs_fall  = cs_act & ~cs_d;
  assign cs_rise  = ~cs_act & cs_d;
  assign sck_rise = cs_act & ~hold & sck_m[1] & ~sck_d;
  assign sck_fall = cs_act & ~hold & ~sck_m[1] & sck_d;

  assert_hold_entry_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> !$past(sck_m[1]));
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/spi_mem_page.sv
module spi_mem_page #(
  parameter int AW = 10,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-PW-1:0] base,
  input  logic          wr,
  input  logic [PW-1:0] off,
  input  logic [7:0]    data,
  input  logic          commit,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data,
  output logic          busy
);
  localparam int PAGE = 1 << PW;

  logic [7:0]      pbuf [0:PAGE-1];
  logic [PAGE-1:0] mask;
  logic [AW-PW-1:0] base_q;
  logic [PW-1:0]   idx;

  always_ff @(posedge clk) begin
    if (wr) pbuf[off] <= data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask     <= '0;
      base_q   <= '0;
      idx      <= '0;
      busy     <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start) begin
        base_q <= base;
        mask   <= '0;
      end
      if (wr) mask[off] <= 1'b1;
      if (commit) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        mem_we   <= mask[idx];
        mem_addr <= {base_q, idx};
        mem_data <= pbuf[idx];
        idx      <= idx + 1'b1;
        if (&idx) busy <= 1'b0;
      end
    end
  end

  assert_wrap_mark_R9: assert property (@(posedge clk) disable iff (rst)
    wr |=> mask[$past(off)]);
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int AW = 10,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          si,
  input  logic          hold,
  input  logic [7:0]    mem_q,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          pg_start,
  output logic [AW-PW-1:0] pg_base,
  output logic          pg_wr,
  output logic [PW-1:0] pg_off,
  output logic [7:0]    pg_data,
  output logic          pg_commit,
  output logic          so_bit,
  output logic          so_en
);
  st_e          st;
  logic [2:0]   bitcnt;
  logic [6:0]   rx;
  logic         is_rd, got, armed, oe;
  logic [7:0]   ahi, txsh;
  logic [5:0]   keep;
  logic [AW-1:0] addr;
  logic [PW-1:0] off;

  logic [7:0]  byte_in, status, tx_src;
  logic [15:0] full_addr;
  logic        done;

  assign byte_in   = {rx, si};
  assign done      = sck_rise && (bitcnt == 3'd7);
  assign status    = {keep, armed, 1'b0};
  assign full_addr = {ahi, byte_in};
  assign tx_src    = (st == S_RD) ? mem_q : status;

  assign rd_en     = done && ((st == S_AL && is_rd) || st == S_RD);
  assign rd_addr   = (st == S_AL) ? full_addr[AW-1:0] : addr + 1'b1;
  assign pg_start  = done && st == S_AL && !is_rd;
  assign pg_base   = full_addr[AW-1:PW];
  assign pg_wr     = done && st == S_WR;
  assign pg_off    = off;
  assign pg_data   = byte_in;
  assign pg_commit = cs_rise && st == S_WR && bitcnt == 3'd0 && got && armed;
  assign so_bit    = txsh[7];
  assign so_en     = oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_SKIP;
      bitcnt <= '0;
      rx     <= '0;
      is_rd  <= 1'b0;
      got    <= 1'b0;
      armed  <= 1'b0;
      oe     <= 1'b0;
      ahi    <= '0;
      txsh   <= '0;
      keep   <= '0;
      addr   <= '0;
      off    <= '0;
    end else if (cs_fall) begin
      st     <= S_OP;
      bitcnt <= '0;
      oe     <= 1'b0;
      got    <= 1'b0;
    end else if (cs_rise) begin
      oe <= 1'b0;
      st <= S_SKIP;
      if (pg_commit) armed <= 1'b0;
    end else if (st != S_BAD) begin
      if (sck_rise) begin
        rx     <= byte_in[6:0];
        bitcnt <= bitcnt + 1'b1;
      end
      if (done) begin
        unique case (st)
          S_OP: begin
            unique case (byte_in)
              OP_ARM_SET: begin armed <= 1'b1; st <= S_SKIP; end
              OP_ARM_CLR: begin armed <= 1'b0; st <= S_SKIP; end
              OP_STAT_RD: st <= S_SRR;
              OP_STAT_WR: st <= S_SRW;
              OP_MEM_RD:  begin is_rd <= 1'b1; st <= S_AH; end
              OP_MEM_WR:  begin is_rd <= 1'b0; st <= S_AH; end
              default: begin st <= S_BAD; oe <= 1'b0; end
            endcase
          end
          S_AH: begin ahi <= byte_in; st <= S_AL; end
          S_AL: begin
            addr <= full_addr[AW-1:0];
            off  <= full_addr[PW-1:0];
            st   <= is_rd ? S_RD : S_WR;
          end
          S_RD: addr <= addr + 1'b1;
          S_WR: begin off <= off + 1'b1; got <= 1'b1; end
          S_SRW: begin
            if (armed) begin
              keep  <= byte_in[7:2];
              armed <= 1'b0;
            end
            st <= S_SKIP;
          end
          default: ;
        endcase
      end
      if (sck_fall) begin
        if (bitcnt == 3'd0) begin
          txsh <= tx_src;
          oe   <= (st == S_RD) || (st == S_SRR);
        end else begin
          txsh <= {txsh[6:0], 1'b0};
        end
      end
    end
  end

  assert_bad_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (st == S_BAD) |-> !oe);
  assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(bitcnt) && $stable(txsh)));
  assert_commit_whole_R8: assert property (@(posedge clk) disable iff (rst)
    pg_commit |=> !armed);
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int DEPTH = 1024,
  parameter int PAGE  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sck,
  input  logic spi_csn,
  input  logic spi_si,
  input  logic spi_holdn,
  output logic spi_so,
  output logic spi_so_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);

  logic cs_act, cs_fall, cs_rise, sck_rise, sck_fall, si_s, hold;
  logic rd_en, pg_start, pg_wr, pg_commit, so_bit, so_en;
  logic [AW-1:0] rd_addr, mem_addr;
  logic [AW-PW-1:0] pg_base;
  logic [PW-1:0] pg_off;
  logic [7:0] pg_data, mem_q, mem_data;
  logic mem_we, pg_busy;

  spi_mem_sync u_sync (
    .clk(clk), .rst(rst), .sck_i(spi_sck), .csn_i(spi_csn), .si_i(spi_si),
    .holdn_i(spi_holdn), .cs_act(cs_act), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s), .hold(hold)
  );

  spi_mem_ctrl #(.AW(AW), .PW(PW)) u_ctrl (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si(si_s), .hold(hold),
    .mem_q(mem_q), .rd_en(rd_en), .rd_addr(rd_addr), .pg_start(pg_start),
    .pg_base(pg_base), .pg_wr(pg_wr), .pg_off(pg_off), .pg_data(pg_data),
    .pg_commit(pg_commit), .so_bit(so_bit), .so_en(so_en)
  );

  spi_mem_page #(.AW(AW), .PW(PW)) u_page (
    .clk(clk), .rst(rst), .start(pg_start), .base(pg_base), .wr(pg_wr),
    .off(pg_off), .data(pg_data), .commit(pg_commit), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_data(mem_data), .busy(pg_busy)
  );

  spi_mem_array #(.AW(AW), .DW(8)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_data),
    .re(rd_en), .raddr(rd_addr), .q(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spi_so    <= 1'b0;
      spi_so_oe <= 1'b0;
    end else begin
      spi_so    <= so_bit;
      spi_so_oe <= so_en & cs_act & ~hold;
    end
  end

  assert_idle_hiz_R5: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !spi_so_oe);
  assert_hold_hiz_R6: assert property (@(posedge clk) disable iff (rst)
    hold |=> !spi_so_oe);
  assert_commit_idle_R8: assert property (@(posedge clk) disable iff (rst)
    pg_commit |-> !pg_busy);
endmodule

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;
  localparam int DEPTH = 256;
  localparam int PAGE  = 32;
  localparam int HP    = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, csn = 1'b1, si = 1'b0, holdn = 1'b1;
  logic so, oe;
  int total = 0, bad = 0;
  logic [7:0] model [0:DEPTH-1];
  logic [7:0] wdat [0:63];

  always #2 clk = ~clk;

  spi_mem_slave #(.DEPTH(DEPTH), .PAGE(PAGE)) u_dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_csn(csn), .spi_si(si),
    .spi_holdn(holdn), .spi_so(so), .spi_so_oe(oe)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] b, input int hold_bit,
                       output logic [7:0] r, output bit oe_all, output bit oe_any);
    oe_all = 1'b1; oe_any = 1'b0; r = '0;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      if (i == hold_bit) begin
        wt(HP); holdn = 1'b0; wt(HP);
        check(oe == 1'b0, "R6 pause off", oe, 0);
        repeat (3) begin sck = 1'b1; si = ~si; wt(HP); sck = 1'b0; wt(HP); end
        check(oe == 1'b0, "R6 pause toggles", oe, 0);
        holdn = 1'b1; wt(HP);
      end
      si = b[i]; wt(HP);
      r[i] = so; oe_all &= oe; oe_any |= oe;
      sck = 1'b1; wt(HP);
    end
  endtask

  task automatic t_begin(input bit m3);
    sck = m3; wt(HP); csn = 1'b0; wt(HP);
  endtask

  task automatic t_end(input bit m3);
    if (!m3) begin sck = 1'b0; wt(HP); end
    csn = 1'b1; wt(2*HP + 48);
  endtask

  task automatic one_op(input bit m3, input logic [7:0] op);
    logic [7:0] r; bit a, y;
    t_begin(m3); xbyte(op, -1, r, a, y); t_end(m3);
  endtask

  task automatic stat_rd(input bit m3, input int n, input logic [7:0] exp, input string req);
    logic [7:0] r; bit a, y;
    t_begin(m3);
    xbyte(8'h05, -1, r, a, y);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, -1, r, a, y);
      check(r == exp && a, req, r, exp);
    end
    t_end(m3);
  endtask

  task automatic mem_wr(input bit m3, input logic [15:0] ad, input int n, input int extra_bits,
                        input bit upd);
    logic [7:0] r; bit a, y; int base, off;
    t_begin(m3);
    xbyte(8'h02, -1, r, a, y); xbyte(ad[15:8], -1, r, a, y); xbyte(ad[7:0], -1, r, a, y);
    for (int k = 0; k < n; k++) xbyte(wdat[k], -1, r, a, y);
    for (int k = 0; k < extra_bits; k++) begin
      sck = 1'b0; si = 1'b1; wt(HP); sck = 1'b1; wt(HP);
    end
    t_end(m3);
    if (upd) begin
      base = (int'(ad) % DEPTH) / PAGE * PAGE;
      off  = int'(ad) % PAGE;
      for (int k = 0; k < n; k++) model[base + (off + k) % PAGE] = wdat[k];
    end
  endtask

  task automatic mem_rd(input bit m3, input logic [15:0] ad, input int n,
                        input int hold_k, input string req);
    logic [7:0] r; bit a, y; int e;
    t_begin(m3);
    xbyte(8'h03, -1, r, a, y); xbyte(ad[15:8], -1, r, a, y);
    xbyte(ad[7:0], -1, r, a, y);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, (k == hold_k) ? 3 : -1, r, a, y);
      e = model[(int'(ad) + k) % DEPTH];
      check(r == e[7:0] && a, req, r, e);
    end
    t_end(m3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1 act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r; bit a, y;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    wt(10); rst = 1'b0; wt(4);
    check(oe == 1'b0, "R5 reset off", oe, 0);
    stat_rd(1'b0, 1, 8'h00, "R7 reset status");

    // arm and disarm in both clock idle levels
    one_op(1'b0, 8'h06);
    stat_rd(1'b1, 1, 8'h02, "R7 armed mode3");
    one_op(1'b1, 8'h04);
    stat_rd(1'b0, 1, 8'h00, "R7 disarmed");

    // fill whole array page by page (R1, R2)
    for (int p = 0; p < DEPTH / PAGE; p++) begin
      for (int j = 0; j < PAGE; j++) wdat[j] = 8'((p * PAGE + j) * 13 + 7);
      one_op(p[0], 8'h06);
      mem_wr(p[0], 16'hA000 | 16'(p * PAGE), PAGE, 0, 1'b1);
      if (p < 2) stat_rd(p[0], 1, 8'h00, "R8 armed cleared");
    end
    mem_rd(1'b0, 16'h3C00, DEPTH, -1, "R3 R2 full read mode0");
    mem_rd(1'b1, 16'hFFF0, 40, -1, "R3 R1 wrap read mode3");

    // page wrap (R9)
    for (int j = 0; j < 40; j++) wdat[j] = 8'(8'h80 + j);
    one_op(1'b0, 8'h06);
    mem_wr(1'b0, 16'h001C, 40, 0, 1'b1);
    mem_rd(1'b0, 16'h0000, 2 * PAGE, -1, "R9 page wrap");

    // write while not armed (R8)
    for (int j = 0; j < 5; j++) wdat[j] = 8'h55;
    mem_wr(1'b1, 16'h0040, 5, 0, 1'b0);
    mem_rd(1'b1, 16'h0040, 5, -1, "R8 not armed");

    // write cut mid-byte (R8)
    one_op(1'b0, 8'h06);
    mem_wr(1'b0, 16'h0040, 3, 3, 1'b0);
    mem_rd(1'b0, 16'h0040, 3, -1, "R8 partial byte");
    stat_rd(1'b0, 1, 8'h02, "R8 armed kept");
    one_op(1'b0, 8'h04);

    // unknown command (R4)
    t_begin(1'b0);
    xbyte(8'hFF, -1, r, a, y); check(!y, "R4 bad op", y, 0);
    for (int k = 0; k < 4; k++) begin
      xbyte((k == 0) ? 8'h03 : 8'h00, -1, r, a, y);
      check(!y, "R4 ignored bytes", y, 0);
    end
    t_end(1'b0);
    t_begin(1'b1);
    xbyte(8'h07, -1, r, a, y); xbyte(8'h06, -1, r, a, y);
    t_end(1'b1);
    stat_rd(1'b0, 1, 8'h00, "R4 arm ignored");

    // deselected activity (R5)
    for (int i = 0; i < 16; i++) begin
      si = (i[3:1] == 3'd1 || i[3:1] == 3'd2) ? 1'b1 : 1'b0;
      sck = ~sck; wt(HP);
      if (oe) check(1'b0, "R5 idle off", oe, 0);
    end
    sck = 1'b0;
    check(oe == 1'b0, "R5 idle off end", oe, 0);
    stat_rd(1'b0, 1, 8'h00, "R5 no state change");

    // status write (R7, R10)
    t_begin(1'b0); xbyte(8'h01, -1, r, a, y); xbyte(8'hFC, -1, r, a, y); t_end(1'b0);
    stat_rd(1'b0, 1, 8'h00, "R7 status write unarmed");
    one_op(1'b1, 8'h06);
    t_begin(1'b1); xbyte(8'h01, -1, r, a, y); xbyte(8'hA9, -1, r, a, y); t_end(1'b1);
    stat_rd(1'b1, 3, 8'hA8, "R10 R7 status repeat");
    one_op(1'b0, 8'h06);
    stat_rd(1'b0, 2, 8'hAA, "R7 keep and armed");
    one_op(1'b0, 8'h04);

    // pause in mid byte (R6)
    mem_rd(1'b0, 16'h0020, 6, 2, "R6 pause mode0");
    mem_rd(1'b1, 16'h0090, 8, 5, "R6 pause mode3");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule